// File: doc/BRIEF.md
# Multiplexed-Bus External Memory Read Controller

This block fetches single bytes from an external byte-wide memory that shares one 8-bit bus between address and data. An internal client raises a request with an address, an address-width select and a wait count. The controller then places the address on the bus one byte at a time, most significant byte first. An external transparent latch captures each byte on the rising edge of an active-low strobe while the active-low memory select is inactive. After the last byte the controller releases the bus for one cycle. It then pulls the select and the strobe low together, so that the same strobe now acts as the memory's output enable. The returned byte is sampled on the final wait cycle and handed back with a one-cycle done pulse.

The bus is exposed as separate out, in and drive-enable signals so that the pad-level tristate buffer stays outside the block. The address width is selected per request: three bytes cover the full 24-bit space and two bytes cover the low 64 KB.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: During and right after reset, strobe_n=1, sel_n=1, bus_oe=0, rsp_valid=0 and req_ready=1.
- R2: req_ready is 1 exactly when the controller is idle. A request is taken at a rising clock edge where req_valid and req_ready are both 1. A req_valid seen while busy is ignored and does not alter the access in flight.
- R3: Address bytes go out most significant first, starting in the cycle after acceptance. With req_wide=1 the bytes are req_addr[23:16], [15:8], [7:0]. With req_wide=0 they are [15:8], [7:0], and bits 23:16 are ignored.
- R4: Each address byte takes two cycles with bus_oe=1 and sel_n=1: strobe_n=0 in the first cycle and strobe_n=1 in the second. The latch edge therefore sees a stable byte.
- R5: After the last address byte there is one turnaround cycle with bus_oe=0 and both strobe_n and sel_n high.
- R6: In the read phase, sel_n and strobe_n fall in the same cycle and stay low for wait_cycles+1 cycles, with bus_oe=0 throughout.
- R7: rsp_data equals bus_in as sampled at the clock edge that ends the last read cycle.
- R8: In the cycle after the read phase, both strobes are high and rsp_valid is 1 for exactly one cycle. The cycle after that is idle with req_ready=1.
- R9: wait_cycles is taken at acceptance, and later changes to it do not change the length of that access's read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W (24) | Byte address |
| req_wide | input | 1 | 1: three address bytes, 0: two |
| wait_cycles | input | WAIT_W (4) | Extra read-phase cycles |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 8 | Byte read from memory |
| bus_out | output | 8 | Value driven on the shared bus |
| bus_oe | output | 1 | Bus drive enable (1 = drive) |
| bus_in | input | 8 | Value seen on the shared bus |
| strobe_n | output | 1 | Active-low latch strobe / output enable |
| sel_n | output | 1 | Active-low memory select |

## Verification
A wrong byte index corrupts the external latch at once. The wrong byte shows on bus_out in that same address cycle, and the address collected at the done pulse disagrees with the request. A stuck or miscounting wait timer shifts the fall of sel_n back to high by whole cycles, which shows in the first cycle after the expected end of the read. Because the bench drives bus_in with inverted data on every read cycle but the last, an early or late capture shows up in rsp_data with the done pulse. A state machine that leaves idle on a request while busy breaks the strobe pattern of the access in flight within one cycle.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALO,
    ST_AHI,
    ST_TURN,
    ST_READ,
    ST_DONE
  } xbr_state_e;

  // Number of address bytes sent for a request.
  function automatic int unsigned xbr_addr_bytes(input logic wide, input int unsigned nb_max);
    return wide ? nb_max : nb_max - 1;
  endfunction

endpackage

// File: rtl/xbr_addr_path.sv
module xbr_addr_path #(
  parameter int ADDR_W = 24,
  parameter int NB_MAX = ADDR_W / 8,
  parameter int IDX_W  = (NB_MAX > 1) ? $clog2(NB_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step,
  output logic [7:0]        byte_out,
  output logic              is_last
);
  import xbr_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] i);
    logic [ADDR_W-1:0] s;
    s = a >> (8 * i);
    return s[7:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      idx_q  <= IDX_W'(xbr_addr_bytes(wide, NB_MAX) - 1);
    end else if (step) begin
      idx_q  <= idx_q - 1'b1;
    end
  end

  assign byte_out = pick_byte(addr_q, idx_q);
  assign is_last  = (idx_q == '0);

endmodule

// File: rtl/xbr_wait_timer.sv
module xbr_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl #(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  input  logic [7:0]        bus_in,
  output logic              strobe_n,
  output logic              sel_n
);
  import xbr_pkg::*;

  localparam int NB_MAX = ADDR_W / 8;
  localparam int IDX_W  = (NB_MAX > 1) ? $clog2(NB_MAX) : 1;

  xbr_state_e state_q, state_d;
  logic [7:0] data_q;
  logic [7:0] cur_byte;
  logic       idx_last;
  logic       wait_done;

  // Named internal events
  logic accept;
  logic addr_step;
  logic addr_last;
  logic read_last;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign addr_step = (state_q == ST_AHI) && !idx_last;
  assign addr_last = (state_q == ST_AHI) && idx_last;
  assign read_last = (state_q == ST_READ) && wait_done;

  xbr_addr_path #(
    .ADDR_W (ADDR_W),
    .NB_MAX (NB_MAX),
    .IDX_W  (IDX_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .wide     (req_wide),
    .addr_in  (req_addr),
    .step     (addr_step),
    .byte_out (cur_byte),
    .is_last  (idx_last)
  );

  xbr_wait_timer #(
    .WAIT_W (WAIT_W)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (wait_cycles),
    .dec      ((state_q == ST_READ) && !wait_done),
    .expired  (wait_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ALO;
      ST_ALO:  state_d = ST_AHI;
      ST_AHI:  state_d = addr_last ? ST_TURN : ST_ALO;
      ST_TURN: state_d = ST_READ;
      ST_READ: if (read_last) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (read_last) data_q <= bus_in;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bus_oe    = (state_q == ST_ALO) || (state_q == ST_AHI);
  assign bus_out   = cur_byte;
  assign strobe_n  = !((state_q == ST_ALO) || (state_q == ST_READ));
  assign sel_n     = (state_q != ST_READ);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_data  = data_q;

endmodule

// File: rtl/xbr_checks.sv
module xbr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       bus_oe,
  input logic [7:0] bus_out,
  input logic       strobe_n,
  input logic       sel_n,
  input logic       rsp_valid
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sel_n && strobe_n && !bus_oe));

  assert_latch_edge_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_n) && bus_oe) |-> $stable(bus_out));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> !$past(bus_oe));

  assert_joint_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> $fell(strobe_n));

  assert_read_strobe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> (!strobe_n && !bus_oe));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (sel_n && strobe_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

bind xbus_rd_ctrl xbr_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .strobe_n  (strobe_n),
  .sel_n     (sel_n),
  .rsp_valid (rsp_valid)
);

// File: tb/sim_xbus_rd_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_rd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_wide = 1'b0;
  logic [3:0]  wait_cycles = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  bus_in = 8'h00;
  logic        strobe_n;
  logic        sel_n;

  always #2 clk = ~clk;

  xbus_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wide(req_wide), .wait_cycles(wait_cycles),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .strobe_n(strobe_n), .sel_n(sel_n)
  );

  // kind: 0 idle, 1 address, 2 turnaround, 3 read, 4 done
  typedef struct {
    int        kind;
    bit        oe;
    bit [7:0]  byt;
    bit        stb;
    bit        sel;
    bit        vld;
    bit        rdy;
    bit        lastrd;
    bit [7:0]  dat;
    bit        wide;
    bit [23:0] adr;
  } exp_t;

  exp_t q[$];
  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [23:0] lat = '0;

  // External address latch model
  always @(posedge strobe_n) if (bus_oe === 1'b1) lat <= {lat[15:0], bus_out};

  function automatic bit [7:0] memf(input bit [23:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic bit [23:0] mask_adr(input bit [23:0] a, input bit w);
    return w ? a : {8'h00, a[15:0]};
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e = '{kind:0, oe:0, byt:0, stb:1, sel:1, vld:0, rdy:1, lastrd:0, dat:0, wide:0, adr:0};
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic push_access(input bit [23:0] a, input bit w, input bit [3:0] wc);
    exp_t e;
    int nb;
    nb = w ? 3 : 2;
    for (int i = nb - 1; i >= 0; i--) begin
      e = idle_e(); e.rdy = 0; e.kind = 1; e.oe = 1;
      e.byt = 8'(a >> (8 * i));
      e.stb = 0; q.push_back(e);
      e.stb = 1; q.push_back(e);
    end
    e = idle_e(); e.rdy = 0; e.kind = 2; q.push_back(e);
    for (int k = 0; k <= int'(wc); k++) begin
      e = idle_e(); e.rdy = 0; e.kind = 3; e.stb = 0; e.sel = 0;
      e.lastrd = (k == int'(wc)); e.wide = w; q.push_back(e);
    end
    e = idle_e(); e.rdy = 0; e.kind = 4; e.vld = 1; e.wide = w;
    e.adr = mask_adr(a, w); e.dat = memf(mask_adr(a, w));
    q.push_back(e);
  endtask

  task automatic cyc(input bit v, input bit [23:0] a, input bit w, input bit [3:0] wc);
    exp_t e;
    string rq;
    @(negedge clk);
    e = (q.size() > 0) ? q.pop_front() : idle_e();
    chk(req_ready === e.rdy, "R2", "req_ready", int'(req_ready), int'(e.rdy));
    rq = (e.kind == 2) ? "R5" : (e.kind == 3) ? "R6/R9" : "R4";
    chk(bus_oe === e.oe, rq, "bus_oe", int'(bus_oe), int'(e.oe));
    chk(strobe_n === e.stb, rq, "strobe_n", int'(strobe_n), int'(e.stb));
    chk(sel_n === e.sel, rq, "sel_n", int'(sel_n), int'(e.sel));
    if (e.oe) chk(bus_out === e.byt, "R3", "bus_out", int'(bus_out), int'(e.byt));
    chk(rsp_valid === e.vld, "R8", "rsp_valid", int'(rsp_valid), int'(e.vld));
    if (e.vld) begin
      chk(rsp_data === e.dat, "R7", "rsp_data", int'(rsp_data), int'(e.dat));
      if (e.wide) chk(lat === e.adr, "R3", "latched address", int'(lat), int'(e.adr));
      else        chk(lat[15:0] === e.adr[15:0], "R3", "latched address", int'(lat[15:0]), int'(e.adr[15:0]));
    end
    // Memory model: correct data only on the final read cycle (R7)
    if (e.kind == 3) bus_in = e.lastrd ? memf(mask_adr(lat, e.wide)) : ~memf(mask_adr(lat, e.wide));
    else             bus_in = 8'h3C;
    req_valid   = v;
    req_addr    = a;
    req_wide    = w;
    wait_cycles = wc;
    if (e.rdy && v) push_access(a, w, wc);
  endtask

  // One access; with poke set, requests with other values are raised while busy (R2, R9)
  task automatic run(input bit [23:0] a, input bit w, input bit [3:0] wc, input bit poke);
    int n;
    cyc(1'b1, a, w, wc);
    n = 0;
    while (q.size() > 0) begin
      n++;
      if (poke) cyc(1'b1, a ^ 24'h5F0F3C ^ 24'(n), ~w, wc + 4'(n) + 4'd5);
      else      cyc(1'b0, 24'h000000, 1'b0, 4'd0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (2) begin
      @(negedge clk);
      chk(strobe_n === 1'b1 && sel_n === 1'b1, "R1", "strobes in reset", int'({strobe_n, sel_n}), 3);
      chk(bus_oe === 1'b0 && rsp_valid === 1'b0, "R1", "oe/valid in reset", int'({bus_oe, rsp_valid}), 0);
      chk(req_ready === 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    end
    rst_n = 1'b1;
    cyc(1'b0, 24'h0, 1'b0, 4'd0);
    cyc(1'b0, 24'h0, 1'b0, 4'd0);
    run(24'h123456, 1'b0, 4'd0, 1'b0);   // R3 narrow, shortest read
    run(24'hABCDEF, 1'b1, 4'd0, 1'b1);   // R3 wide, R2 pokes
    run(24'h000000, 1'b1, 4'd15, 1'b1);  // R6 longest wait, R9 wait changes ignored
    cyc(1'b0, 24'h0, 1'b0, 4'd0);
    run(24'hFFFFFF, 1'b0, 4'd3, 1'b1);   // R3 upper byte ignored in narrow mode
    run(24'h800001, 1'b1, 4'd1, 1'b0);   // back to back with previous
    run(24'h5AA55A, 1'b1, 4'd7, 1'b0);
    run(24'h00FF00, 1'b0, 4'd2, 1'b1);
    repeat (3) cyc(1'b0, 24'h0, 1'b0, 4'd0);  // R8 stays idle
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

endmodule